// File: doc/BRIEF.md
# Lane Capture Delay Calibrator

This block finds a good capture delay for each deserialized ADC data lane. Each lane's input path has a tap-based delay element whose setting this block drives. While the converter sends a counting (ramp) test pattern, the block walks the lane under test through every delay tap. At each tap it waits a settling time and then checks a window of received samples against the ramp. It records whether that tap was error-free.

Some taps give almost continuous errors and others give none, so every tap in the range is measured. After the sweep, the lane is set to the middle tap of the longest unbroken run of error-free taps. That choice keeps the most timing margin on both sides. Lanes are calibrated one at a time, lowest index first.

When the last lane is finished, a done flag rises and the chosen taps stay on the tap outputs until the next start. A lane with no error-free tap gets a per-lane fail flag. Setting up the converter's test mode is handled elsewhere.

Top module: `lane_skew_calibrator`

## Requirements
- R1: After reset, every lane's tap output is 0 and busy, done and every fail bit are 0.
- R2: A start pulse while not busy makes busy 1 and done 0 from the next cycle.
- R3: Lanes are calibrated one after another, lowest index first. The lane under test steps through taps 0, 1, ... NUM_TAPS-1 in ascending order, each step adding one. Only one lane's tap output changes in any cycle.
- R4: At each tap, the block first waits settle_len+1 cycles. It then checks a window of win_len samples of the lane under test (win_len of at least 2), counting only cycles with rx_valid high. Each sample must equal the previous sample plus one, modulo 2^SAMPLE_W. The comparison resynchronizes to the received value after a mismatch. A single mismatch in the window marks the tap bad.
- R5: For each lane, the chosen tap is S + (L-1)/2, rounded down, where S is the first tap and L the length of the longest run of consecutive good taps. When two runs have the same length, the lower run wins.
- R6: A lane with no good tap has its fail bit (bit index = lane) set to 1 and its tap output set to 0.
- R7: After the last lane, busy falls and done rises in the same cycle. The tap outputs then hold their values, whatever the received data, until the next start.
- R8: A start pulse while busy is ignored: the sweep continues and its results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin calibrating all lanes |
| settle_len | input | SETTLE_W | Settling cycles after each tap change (plus one) |
| win_len | input | WIN_W | Valid samples checked per tap (at least 2) |
| rx_valid | input | 1 | Received samples on all lanes are valid this cycle |
| rx_data | input | NUM_LANES*SAMPLE_W | Received samples; lane i at bits [i*SAMPLE_W +: SAMPLE_W] |
| tap_value | output | NUM_LANES*TAP_W | Delay tap per lane; lane i at bits [i*TAP_W +: TAP_W] |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | All lanes calibrated |
| fail | output | NUM_LANES | Per-lane flag: no error-free tap found |

## Verification
On every cycle, the assertions check that busy and done never overlap and that a start from idle raises busy. They also check that no more than one lane's tap moves per cycle, that fail bits show only during or after a run, and that idle taps stay stable. The tap picked in each case can only be shown by the bench scenarios. These include single runs at the range edges, equal-length runs, a longer later run, lanes with no good tap, marginal taps with only sparse errors, and gaps in rx_valid. Lane order and the ascending one-step sweep are tracked by a bench monitor.

// File: rtl/lane_cal_pkg.sv
package lane_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETTLE,
    ST_MEASURE,
    ST_EVAL,
    ST_PICK
  } cal_state_t;
endpackage

// File: rtl/lane_sample_select.sv
module lane_sample_select #(
  parameter int NUM_LANES = 4,
  parameter int SAMPLE_W  = 12,
  parameter int LANE_W    = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LANE_W-1:0]             sel,
  input  logic                          in_valid,
  input  logic [NUM_LANES*SAMPLE_W-1:0] in_data,
  output logic                          out_valid,
  output logic [SAMPLE_W-1:0]           out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_data  <= in_data[sel*SAMPLE_W +: SAMPLE_W];
    end
  end
endmodule

// File: rtl/ramp_error_counter.sv
module ramp_error_counter #(
  parameter int SAMPLE_W = 12,
  parameter int ERR_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                en,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                clean
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic                primed;
  logic [SAMPLE_W-1:0] prev;
  logic [ERR_W-1:0]    errs;
  logic                mismatch;

  assign mismatch = primed && (sample != SAMPLE_W'(prev + 1'b1));
  assign clean    = (errs == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      primed <= 1'b0;
      prev   <= '0;
      errs   <= '0;
    end else if (en) begin
      primed <= 1'b1;
      prev   <= sample;  // resync to what arrived
      if (mismatch && errs != ERR_MAX) errs <= errs + 1'b1;
    end
  end
endmodule

// File: rtl/good_run_tracker.sv
module good_run_tracker #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             upd,
  input  logic             ok,
  input  logic [TAP_W-1:0] tap,
  output logic [TAP_W-1:0] best_start,
  output logic [TAP_W:0]   best_len
);
  logic [TAP_W-1:0] cur_start;
  logic [TAP_W:0]   cur_len;
  logic [TAP_W-1:0] run_start;
  logic [TAP_W:0]   run_len;

  assign run_start = (cur_len == '0) ? tap : cur_start;
  assign run_len   = cur_len + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur_start  <= '0;
      cur_len    <= '0;
      best_start <= '0;
      best_len   <= '0;
    end else if (upd) begin
      if (ok) begin
        cur_start <= run_start;
        cur_len   <= run_len;
        if (run_len > best_len) begin  // strict: lower run wins ties
          best_start <= run_start;
          best_len   <= run_len;
        end
      end else begin
        cur_len <= '0;
      end
    end
  end
endmodule

// File: rtl/lane_skew_calibrator.sv
module lane_skew_calibrator
  import lane_cal_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int SAMPLE_W  = 12,
  parameter int NUM_TAPS  = 32,
  parameter int SETTLE_W  = 8,
  parameter int WIN_W     = 10,
  parameter int ERR_W     = 8,
  localparam int TAP_W    = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1,
  localparam int LANE_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [SETTLE_W-1:0]           settle_len,
  input  logic [WIN_W-1:0]              win_len,
  input  logic                          rx_valid,
  input  logic [NUM_LANES*SAMPLE_W-1:0] rx_data,
  output logic [NUM_LANES*TAP_W-1:0]    tap_value,
  output logic                          busy,
  output logic                          done,
  output logic [NUM_LANES-1:0]          fail
);
  localparam logic [TAP_W-1:0]  LAST_TAP  = TAP_W'(NUM_TAPS - 1);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

  cal_state_t         state;
  logic [LANE_W-1:0]  lane;
  logic [TAP_W-1:0]   tap;
  logic [SETTLE_W-1:0] settle_cnt;
  logic [WIN_W-1:0]   win_cnt;
  logic [TAP_W-1:0]   taps_q [NUM_LANES];

  logic                sel_valid;
  logic [SAMPLE_W-1:0] sel_data;
  logic                chk_clean;
  logic                chk_en;
  logic [TAP_W-1:0]    best_start;
  logic [TAP_W:0]      best_len;
  logic [TAP_W-1:0]    mid_tap;

  assign chk_en  = (state == ST_MEASURE) && sel_valid;
  assign mid_tap = best_start + TAP_W'((best_len - 1'b1) >> 1);

  lane_sample_select #(
    .NUM_LANES(NUM_LANES), .SAMPLE_W(SAMPLE_W), .LANE_W(LANE_W)
  ) u_select (
    .clk(clk), .rst(rst), .sel(lane), .in_valid(rx_valid), .in_data(rx_data),
    .out_valid(sel_valid), .out_data(sel_data)
  );

  ramp_error_counter #(.SAMPLE_W(SAMPLE_W), .ERR_W(ERR_W)) u_check (
    .clk(clk), .rst(rst), .clr(state != ST_MEASURE), .en(chk_en),
    .sample(sel_data), .clean(chk_clean)
  );

  good_run_tracker #(.TAP_W(TAP_W)) u_runs (
    .clk(clk), .rst(rst),
    .clr((state == ST_IDLE) || (state == ST_PICK)),
    .upd(state == ST_EVAL), .ok(chk_clean), .tap(tap),
    .best_start(best_start), .best_len(best_len)
  );

  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_tap_out
      assign tap_value[i*TAP_W +: TAP_W] = taps_q[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      lane       <= '0;
      tap        <= '0;
      settle_cnt <= '0;
      win_cnt    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      fail       <= '0;
      for (int i = 0; i < NUM_LANES; i++) taps_q[i] <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            busy  <= 1'b1;
            done  <= 1'b0;
            fail  <= '0;
            lane  <= '0;
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          tap          <= '0;
          taps_q[lane] <= '0;
          settle_cnt   <= '0;
          state        <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settle_cnt >= settle_len) begin
            win_cnt <= '0;
            state   <= ST_MEASURE;
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        ST_MEASURE: begin
          if (sel_valid) begin
            if (win_cnt == win_len - 1'b1) state <= ST_EVAL;
            else win_cnt <= win_cnt + 1'b1;
          end
        end
        ST_EVAL: begin
          if (tap == LAST_TAP) begin
            state <= ST_PICK;
          end else begin
            tap          <= tap + 1'b1;
            taps_q[lane] <= tap + 1'b1;
            settle_cnt   <= '0;
            state        <= ST_SETTLE;
          end
        end
        ST_PICK: begin
          if (best_len == '0) begin
            fail[lane]   <= 1'b1;
            taps_q[lane] <= '0;
          end else begin
            taps_q[lane] <= mid_tap;
          end
          if (lane == LAST_LANE) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            lane  <= lane + 1'b1;
            state <= ST_LOAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lane_cal_checker.sv
module lane_cal_checker #(
  parameter int NUM_LANES = 4,
  parameter int TAP_W     = 5
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       start,
  input logic                       busy,
  input logic                       done,
  input logic [NUM_LANES-1:0]       fail,
  input logic [NUM_LANES*TAP_W-1:0] tap_value
);
  logic [NUM_LANES*TAP_W-1:0] prev_taps;
  logic                       prev_ok;
  logic [NUM_LANES-1:0]       moved;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_taps <= '0;
      prev_ok   <= 1'b0;
    end else begin
      prev_taps <= tap_value;
      prev_ok   <= 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_LANES; i++)
      moved[i] = (tap_value[i*TAP_W +: TAP_W] != prev_taps[i*TAP_W +: TAP_W]);
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!busy && !done && fail == '0));

  a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done));

  a_r3_one_lane_moves: assert property (@(posedge clk) disable iff (rst)
    prev_ok |-> ($countones(moved) <= 1));

  a_r6_fail_only_with_run: assert property (@(posedge clk) disable iff (rst)
    (fail != '0) |-> (busy || done));

  a_r7_busy_done_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r7_done_on_busy_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(tap_value));
endmodule

bind lane_skew_calibrator lane_cal_checker #(
  .NUM_LANES(NUM_LANES), .TAP_W(TAP_W)
) u_lane_cal_checker (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .fail(fail), .tap_value(tap_value)
);

// File: tb/test_lane_skew_calibrator.sv
module test_lane_skew_calibrator;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 4;
  localparam int SW   = 12;
  localparam int NT   = 32;
  localparam int TW   = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [7:0]        settle_len = 8'd4;
  logic [9:0]        win_len = 10'd24;
  logic              rx_valid = 1'b0;
  logic [NL*SW-1:0]  rx_data = '0;
  logic [NL*TW-1:0]  tap_value;
  logic              busy, done;
  logic [NL-1:0]     fail;

  int checks = 0;
  int fails  = 0;
  int cycle  = 0;

  logic [NT-1:0] mask [NL];
  logic [SW-1:0] ramp [NL];
  bit sparse_mode = 0;
  bit gap_mode    = 0;

  int steps [NL];
  int first_step [NL];
  int prev_tap [NL];

  lane_skew_calibrator #(
    .NUM_LANES(NL), .SAMPLE_W(SW), .NUM_TAPS(NT), .SETTLE_W(8), .WIN_W(10)
  ) i_lane_skew_calibrator (
    .clk(clk), .rst(rst), .start(start), .settle_len(settle_len),
    .win_len(win_len), .rx_valid(rx_valid), .rx_data(rx_data),
    .tap_value(tap_value), .busy(busy), .done(done), .fail(fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  function automatic int lane_tap(input int l);
    return int'(tap_value[l*TW +: TW]);
  endfunction

  // Converter plus delay-line model: good taps give a clean ramp.
  always @(negedge clk) begin
    automatic bit v = gap_mode ? ((cycle % 3) != 2) : 1'b1;
    rx_valid = v;
    for (int l = 0; l < NL; l++) begin
      automatic logic [SW-1:0] d;
      if (v) ramp[l] = ramp[l] + 1'b1;
      d = ramp[l];
      if (!mask[l][lane_tap(l)]) begin
        if (sparse_mode) begin
          if (ramp[l][3:0] == 4'd0) d[SW-1] = ~d[SW-1];
        end else if (ramp[l][0]) begin
          d[SW-1] = ~d[SW-1];
        end
      end
      rx_data[l*SW +: SW] = d;
    end
  end

  // Sweep monitor for R3
  always @(negedge clk) begin
    for (int l = 0; l < NL; l++) begin
      if (busy && lane_tap(l) == prev_tap[l] + 1) begin
        steps[l]++;
        if (first_step[l] == 0) first_step[l] = cycle;
      end
      prev_tap[l] = lane_tap(l);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [NT-1:0] span(input int lo, input int hi);
    logic [NT-1:0] m = '0;
    for (int t = lo; t <= hi; t++) m[t] = 1'b1;
    return m;
  endfunction

  // Expected choice: returns tap, sets nogood when no good tap
  function automatic int pick(input logic [NT-1:0] m, output bit nogood);
    int cs = 0, cl = 0, bs = 0, bl = 0;
    for (int t = 0; t < NT; t++) begin
      if (m[t]) begin
        if (cl == 0) cs = t;
        cl++;
        if (cl > bl) begin bl = cl; bs = cs; end
      end else cl = 0;
    end
    nogood = (bl == 0);
    return nogood ? 0 : bs + (bl - 1) / 2;
  endfunction

  task automatic run_and_check(input string tag, input bit poke_start);
    for (int l = 0; l < NL; l++) begin
      steps[l] = 0; first_step[l] = 0;
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({tag, " R2 busy"}, int'(busy), 1);
    check({tag, " R2 done low"}, int'(done), 0);
    if (poke_start) begin
      repeat (3000) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;  // R8 ignored
    end
    while (!done && cycle < 180000) @(negedge clk);
    check({tag, " R7 done"}, int'(done), 1);
    check({tag, " R7 busy low"}, int'(busy), 0);
    for (int l = 0; l < NL; l++) begin
      bit ng;
      int et = pick(mask[l], ng);
      check($sformatf("%s R5 lane %0d tap", tag, l), lane_tap(l), et);
      check($sformatf("%s R6 lane %0d fail", tag, l), int'(fail[l]), int'(ng));
      check($sformatf("%s R3 lane %0d steps", tag, l), steps[l], NT - 1);
      if (l > 0)
        check($sformatf("%s R3 lane %0d order", tag, l),
              int'(first_step[l] > first_step[l-1]), 1);
    end
  endtask

  task automatic test_reset();
    for (int l = 0; l < NL; l++) begin
      check($sformatf("R1 lane %0d tap", l), lane_tap(l), 0);
    end
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 fail", int'(fail), 0);
  endtask

  task automatic test_basic();
    mask[0] = span(10, 17);
    mask[1] = span(4, 8);
    mask[2] = '1;
    mask[3] = '0;
    sparse_mode = 0; gap_mode = 0;
    run_and_check("basic/R8", 1'b1);
  endtask

  task automatic test_ties_edges();
    mask[0] = span(2, 5) | span(20, 23);
    mask[1] = span(0, 3) | span(9, 20);
    mask[2] = span(28, 31);
    mask[3] = span(0, 2);
    sparse_mode = 1; gap_mode = 1;  // R4 marginal taps and valid gaps
    run_and_check("ties/R4", 1'b0);
  endtask

  task automatic test_hold();
    int snap [NL];
    for (int l = 0; l < NL; l++) snap[l] = lane_tap(l);
    for (int l = 0; l < NL; l++) mask[l] = ~mask[l];
    sparse_mode = 0; gap_mode = 0;
    repeat (200) @(negedge clk);
    for (int l = 0; l < NL; l++)
      check($sformatf("R7 hold lane %0d", l), lane_tap(l), snap[l]);
    check("R7 done held", int'(done), 1);
  endtask

  initial begin
    for (int l = 0; l < NL; l++) begin
      mask[l] = '1; ramp[l] = SW'(l * 100); prev_tap[l] = 0;
      steps[l] = 0; first_step[l] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_basic();
    test_ties_edges();
    test_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule